// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that gives a host access to PHY registers over a two-wire serial link. It supports both the classic 32-register framing and the extended framing with separate address cycles. The host sees four 32-bit word registers: configuration/status, control, data and address. Frames start as a side effect of register writes:

- writing the address register issues an extended-mode address frame;
- writing the data register issues a write frame;
- writing the control register with its read bit set issues a read frame.

The line clock is produced from the system clock by a programmable divider. It runs only while a frame is in flight. The bidirectional data line is presented as three signals: an output, an output enable and an input.

The frame engine is a single state machine with five states: ST_IDLE, ST_PRE, ST_HDR, ST_TA and ST_DATA. A launch takes ST_IDLE to ST_PRE, or straight to ST_HDR when the preamble is disabled. Bit positions in a frame run from 0 to 63. On each falling line-clock edge the engine advances one bit, and the state changes at fixed positions:

- from ST_PRE to ST_HDR after bit 31;
- from ST_HDR to ST_TA after bit 45;
- from ST_TA to ST_DATA after bit 47;
- from ST_DATA back to ST_IDLE after bit 63.

Read data and the turnaround check are sampled on rising line-clock edges.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at word offsets 12 (config/status), 13 (control), 14 (data) and 15 (address). Reading config/status returns the divider in bits 15:8, the extended-mode select in bit 6, the read-error flag in bit 1 and busy in bit 0, with all other bits 0. Control keeps bits 15:14 and 11:0 as written and reads 0 in bits 13:12 and 31:16. The address register returns its low 16 bits.
- R2: The line clock is low whenever no frame is in flight. While a frame is in flight, its period is 2*D system clocks, where D is the divider field; a value of 0 acts as 1.
- R3: Busy (config/status bit 0) is set from the clock edge that accepts a launching write until the frame ends. The output enable is low while idle. A frame is 64 bits long, or 32 bits when control bit 10 (preamble disable) is set, in which case the leading 32 ones are omitted.
- R4: In classic mode (bit 6 clear), a data-register write sends, MSB first:
  - 32 ones of preamble;
  - start 01 and opcode 01;
  - the port from control bits 9:5;
  - the register from control bits 4:0;
  - turnaround 10;
  - the 16 data bits.
- R5: In extended mode (bit 6 set), an address-register write sends start 00 and opcode 00, the port and device, turnaround 10, and then the 16-bit address.
- R6: In extended mode, a data-register write sends start 00 and opcode 01, followed by the same fields as in R4.
- R7: A control write with bit 15 set sends a read frame: opcode 10 in classic mode, 11 in extended mode. The output enable drops for the 2 turnaround bits and the 16 data bits. The sampled value then appears in data register bits 15:0.
- R8: If the line is high when the second turnaround bit is sampled, the read-error flag is set and the data register reads 0xFFFF. The flag is cleared when the next read launches and changes at no other time.
- R9: No frame is launched by a write while busy is set, nor by an address write in classic mode. Such writes still store their values.
- R10: The data output and output enable change only on falling line-clock edges or at launch. Input is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | OFS_W | Word offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management line clock |
| mdio_o | output | 1 | Serial data output |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data input from the line |

## Verification
Frames are captured bit by bit on the line and compared in full against frames built by the bench. The stimulus is random across mode, operation, port, device, data, preamble setting and divider. Write and address frames show whether start, opcode and field placement are right. Reads from a responding PHY and from an absent one separate correct data capture from the error path, and a following good read shows that the error flag clears. Directed cases cover the rest:

- a divider of 0, which pins the clock period at its shortest;
- writes issued during a frame, which must not launch anything;
- an address write in classic mode, which must launch nothing.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FIELD_W   = 5;
    localparam int WORD_W    = 16;
    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam int OFS_STAT = 12;
    localparam int OFS_CTL  = 13;
    localparam int OFS_DATA = 14;
    localparam int OFS_ADDR = 15;

    localparam logic [15:0] CTL_KEEP = 16'hCFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    typedef struct packed {
        logic [1:0]         st;
        logic [1:0]         op;
        logic [FIELD_W-1:0] port;
        logic [FIELD_W-1:0] dev;
        logic [WORD_W-1:0]  data;
        logic               rd;
        logic               no_pre;
    } mdio_req_t;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam logic [DIV_W-1:0] ONE = 1;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic             wrap;

    always_comb begin
        half     = (div == '0) ? ONE : div;
        wrap     = (cnt >= half - ONE);
        rise_stb = en && wrap && !mdc;
        fall_stb = en && wrap && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mdio_req_t         req,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] IDX_PRE_END = IDX_W'(31);
    localparam logic [IDX_W-1:0] IDX_HDR_END = IDX_W'(45);
    localparam logic [IDX_W-1:0] IDX_TA_END  = IDX_W'(47);
    localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_HDR_GO  = IDX_W'(32);
    localparam logic [IDX_W-1:0] IDX_STEP    = IDX_W'(1);

    mdio_state_e          state;
    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] frame;
    logic                 is_rd;
    logic [WORD_W-1:0]    shreg;
    logic                 err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            frame <= '0;
            is_rd <= 1'b0;
            shreg <= '0;
            err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        frame <= {{32{1'b1}}, req.st, req.op, req.port, req.dev,
                                  (req.rd ? 2'b11 : 2'b10), req.data};
                        is_rd <= req.rd;
                        idx   <= req.no_pre ? IDX_HDR_GO : '0;
                        state <= req.no_pre ? ST_HDR : ST_PRE;
                        if (req.rd) begin
                            err <= 1'b0;
                        end
                    end
                end
                ST_PRE, ST_HDR, ST_TA, ST_DATA: begin
                    if (rise_stb && is_rd) begin
                        if (state == ST_TA && idx == IDX_TA_END) begin
                            err <= mdio_i;
                        end
                        if (state == ST_DATA) begin
                            shreg <= {shreg[WORD_W-2:0], mdio_i};
                        end
                    end
                    if (fall_stb) begin
                        idx <= idx + IDX_STEP;
                        if (idx == IDX_PRE_END) begin
                            state <= ST_HDR;
                        end else if (idx == IDX_HDR_END) begin
                            state <= ST_TA;
                        end else if (idx == IDX_TA_END) begin
                            state <= ST_DATA;
                        end else if (idx == IDX_LAST) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        mdio_oe = (state == ST_PRE) || (state == ST_HDR) ||
                  (((state == ST_TA) || (state == ST_DATA)) && !is_rd);
        mdio_o  = (state == ST_IDLE) ? 1'b1 : frame[~idx];
        rd_done = (state == ST_DATA) && fall_stb && (idx == IDX_LAST) && is_rd;
        rd_data = shreg;
        rd_err  = err;
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [15:0]      ctl_q;
    logic [15:0]      data_q;
    logic [15:0]      addr_q;
    logic             c45_q;
    logic [DIV_W-1:0] div_q;

    logic wr_stat, wr_ctl, wr_data, wr_addr;
    logic go_rd, go_wr, go_ad, launch;
    logic busy, rd_done, rd_err, rise_stb, fall_stb;
    logic [WORD_W-1:0] rd_data;
    logic [15:0]       ctl_src;
    mdio_req_t         req;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[31:16], reg_wdata[7], reg_wdata[5:0]};

    always_comb begin
        wr_stat = reg_wr && (reg_addr == OFS_W'(OFS_STAT));
        wr_ctl  = reg_wr && (reg_addr == OFS_W'(OFS_CTL));
        wr_data = reg_wr && (reg_addr == OFS_W'(OFS_DATA));
        wr_addr = reg_wr && (reg_addr == OFS_W'(OFS_ADDR));
        go_rd   = wr_ctl && reg_wdata[15];
        go_wr   = wr_data;
        go_ad   = wr_addr && c45_q;
        launch  = !busy && (go_rd || go_wr || go_ad);

        ctl_src    = wr_ctl ? reg_wdata[15:0] : ctl_q;
        req.st     = c45_q ? 2'b00 : 2'b01;
        req.op     = go_rd ? (c45_q ? 2'b11 : 2'b10) : (go_ad ? 2'b00 : 2'b01);
        req.port   = ctl_src[9:5];
        req.dev    = ctl_src[4:0];
        req.data   = reg_wdata[15:0];
        req.rd     = go_rd;
        req.no_pre = ctl_src[10];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
            c45_q  <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_stat) begin
                c45_q <= reg_wdata[6];
                div_q <= reg_wdata[8 +: DIV_W];
            end
            if (wr_ctl) begin
                ctl_q <= reg_wdata[15:0] & CTL_KEEP;
            end
            if (wr_addr) begin
                addr_q <= reg_wdata[15:0];
            end
            if (rd_done) begin
                data_q <= rd_err ? 16'hFFFF : rd_data;
            end else if (wr_data) begin
                data_q <= reg_wdata[15:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_W'(OFS_STAT): begin
                reg_rdata[8 +: DIV_W] = div_q;
                reg_rdata[6]          = c45_q;
                reg_rdata[1]          = rd_err;
                reg_rdata[0]          = busy;
            end
            OFS_W'(OFS_CTL):  reg_rdata[15:0] = ctl_q;
            OFS_W'(OFS_DATA): reg_rdata[15:0] = data_q;
            OFS_W'(OFS_ADDR): reg_rdata[15:0] = addr_q;
            default:          reg_rdata = '0;
        endcase
    end

    mdio_clk_div #(.DIV_W(DIV_W)) i_clk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .div      (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .req      (req),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .rd_done  (rd_done),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic busy,
    input logic rd_err,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R2
    AST_OE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R3
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R10
    AST_LAUNCH_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr)); // R9
    AST_ERR_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(rd_err)); // R8
    AST_OE_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_oe)); // R10
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .busy    (busy),
    .rd_err  (rd_err),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int          nchk = 0;
    int          nerr = 0;
    int          cyc = 0;
    int          nrise = 0;
    int          noe = 0;
    int          t0 = 0;
    int          t1 = 0;
    int          base = 0;
    bit          present = 1'b1;
    logic [15:0] phy_val = 16'h0;
    logic [63:0] cap = 64'h0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // line capture on rising line-clock edges
    initial forever begin
        @(posedge mdc);
        cap = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
        if (!mdio_oe) noe++;
        if (nrise == 0) t0 = cyc;
        if (nrise == 1) t1 = cyc;
        nrise++;
    end

    // PHY model drives on falling edges
    initial forever begin
        @(negedge mdc);
        begin
            int pos;
            pos = nrise + base;
            if (pos == 47) mdio_i = present ? 1'b0 : 1'b1;
            else if (pos >= 48 && pos <= 63 && present) mdio_i = phy_val[63 - pos];
            else mdio_i = 1'b1;
        end
    end

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input int ofs, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 4'(ofs);
        reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input int ofs, output logic [31:0] val);
        reg_addr = 4'(ofs);
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            @(negedge clk);
            bus_rd(12, v);
            n++;
        end while (v[0] && n < 5000);
    endtask

    function automatic logic [63:0] exp_frame(input int kind, input bit c45,
        input logic [4:0] port, input logic [4:0] dev, input logic [15:0] dat,
        input bit pres, input logic [15:0] phyd);
        logic [1:0] st, op, ta;
        logic [15:0] d;
        st = c45 ? 2'b00 : 2'b01;
        op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
        ta = (kind == 2 && !pres) ? 2'b11 : 2'b10;
        d  = (kind == 2) ? (pres ? phyd : 16'hFFFF) : dat;
        return {32'hFFFF_FFFF, st, op, port, dev, ta, d};
    endfunction

    // kind: 0 address, 1 write, 2 read
    task automatic run_op(input int kind, input bit c45, input logic [4:0] port,
        input logic [4:0] dev, input logic [15:0] dat, input bit pre_off,
        input logic [7:0] div, input bit pres);
        logic [31:0] v;
        logic [15:0] ctl;
        logic [63:0] mask, ef;
        int hd;
        ctl = {5'b0, pre_off, port, dev};
        bus_wr(12, {16'h0, div, 1'b0, c45, 6'b0});
        bus_wr(13, {16'h0, ctl});
        nrise = 0; noe = 0; cap = 64'h0;
        base = pre_off ? 32 : 0;
        present = pres; phy_val = dat; mdio_i = 1'b1;
        if (kind == 0) bus_wr(15, {16'h0, dat});
        else if (kind == 1) bus_wr(14, {16'h0, dat});
        else bus_wr(13, {16'h0, ctl | 16'h8000});
        bus_rd(12, v);
        chk(64'(v[0]), 64'd1, "R3 busy after launch");
        wait_idle();
        hd = (div == 8'd0) ? 1 : int'(div);
        chk(64'(nrise), pre_off ? 64'd32 : 64'd64, "R3 frame length");
        mask = pre_off ? 64'h0000_0000_FFFF_FFFF : {64{1'b1}};
        ef = exp_frame(kind, c45, port, dev, dat, pres, dat);
        chk(cap & mask, ef & mask,
            kind == 0 ? "R5 address frame" : kind == 1 ? (c45 ? "R6 ext write frame" : "R4 classic write frame")
                      : "R7 read frame");
        chk(64'(t1 - t0), 64'(2 * hd), "R2 line clock period");
        chk(64'(noe), (kind == 2) ? 64'd18 : 64'd0, "R7 released bits");
        if (kind == 2) begin
            bus_rd(14, v);
            chk(64'(v), pres ? 64'(dat) : 64'hFFFF, "R8 R7 read data");
            bus_rd(12, v);
            chk(64'(v[1]), pres ? 64'd0 : 64'd1, "R8 read error flag");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int rs;
        rs = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(12, v);
        chk(64'(v), 64'd0, "R1 reset status");
        chk(64'({mdc, mdio_oe}), 64'd0, "R2 R3 idle lines after reset");

        // register readback
        bus_wr(12, 32'hFFFF_FFFF);
        bus_rd(12, v);
        chk(64'(v), 64'h0000_FF40, "R1 status readback");
        bus_wr(13, 32'hFFFF_7FFF);
        bus_rd(13, v);
        chk(64'(v), 64'h0000_4FFF, "R1 control readback");
        bus_wr(12, 32'h0);
        bus_wr(15, 32'hABCD_1234);
        bus_rd(15, v);
        chk(64'(v), 64'h1234, "R1 address readback");
        repeat (3) @(negedge clk);
        bus_rd(12, v);
        chk(64'({v[0], 31'(nrise)}), 64'd0, "R9 classic address write no frame");

        // directed frames
        run_op(1, 1'b0, 5'h15, 5'h0A, 16'hA55A, 1'b0, 8'd2, 1'b1);
        run_op(0, 1'b1, 5'h01, 5'h1F, 16'h8001, 1'b0, 8'd1, 1'b1);
        run_op(1, 1'b1, 5'h1F, 5'h03, 16'h00FF, 1'b1, 8'd3, 1'b1);
        run_op(2, 1'b1, 5'h02, 5'h04, 16'hC3E1, 1'b0, 8'd0, 1'b1);
        run_op(2, 1'b0, 5'h07, 5'h11, 16'h1234, 1'b1, 8'd2, 1'b0);
        run_op(2, 1'b0, 5'h07, 5'h11, 16'h5A0F, 1'b1, 8'd1, 1'b1);

        // writes during a frame must not launch
        bus_wr(12, 32'h0000_0140);
        bus_wr(13, 32'h0000_0422);
        nrise = 0; base = 32;
        bus_wr(14, 32'h0000_1111);
        repeat (4) @(negedge clk);
        bus_wr(14, 32'h0000_2222);
        bus_wr(15, 32'h0000_3333);
        wait_idle();
        repeat (20) @(negedge clk);
        bus_rd(12, v);
        chk(64'({v[0], 31'(nrise)}), 64'd32, "R9 no launch while busy");
        bus_rd(14, v);
        chk(64'(v), 64'h2222, "R9 value stored while busy");

        // random mix
        for (int i = 0; i < 24; i++) begin
            int k;
            bit c;
            k = int'($urandom % 3);
            c = 1'($urandom % 2);
            if (!c && k == 0) k = 1;
            run_op(k, c, 5'($urandom), 5'($urandom), 16'($urandom), 1'($urandom % 2),
                   8'($urandom % 4), ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule